// File: doc/BRIEF.md
# Universal Shift Register with Shared Parallel Pins

This block is a rising-edge register of `WIDTH` bits (eight by default) with four operations picked by a two-bit mode select: hold, shift toward the most significant bit, shift toward the least significant bit, and parallel load. The register's parallel data goes in and out through one set of shared pins. Here each pin is split into three vectors: `pad_i` (the value seen on the pin), `pad_o` (the value to drive) and `pad_oe` (drive enable). A bidirectional wrapper placed on top joins them back into real pins.

An active-low reset, sampled on the clock, clears the register whatever the mode. Two active-low enables gate the drive onto the shared pins. The drive is also released during a parallel load, so that outside data can reach the pins. The two end bits have their own serial outputs, which are always valid. Each end also has a serial input. Several blocks can therefore be chained into a longer shift register.

The data interface is plain pins rather than valid/ready. Every operation completes in one cycle and cannot stall, so there is no back-pressure.

Top module: `usr_shift_reg`

## Requirements
- R1: When `srst_n` is 0 at a rising edge, every register bit becomes 0. This holds for any value of `mode`.
- R2: With `srst_n`=1 and `mode`=2'b11 (load), bit i takes `pad_i[i]` at the rising edge.
- R3: With `srst_n`=1 and `mode`=2'b01 (shift up), bit 0 takes `ser_in_lo` and bit i takes the old bit i-1.
- R4: With `srst_n`=1 and `mode`=2'b10 (shift down), bit WIDTH-1 takes `ser_in_hi` and bit i takes the old bit i+1.
- R5: With `srst_n`=1 and `mode`=2'b00 (hold), the register keeps its value.
- R6: `pad_oe` is all ones only when `en_a_n`=0, `en_b_n`=0 and `mode`!=2'b11. In every other case it is all zeros. It is combinational and follows its inputs in the same cycle.
- R7: `pad_o` always shows the register. `ser_out_lo` shows bit 0 and `ser_out_hi` shows bit WIDTH-1, whatever the enables are.
- R8: Reset, shift, load and hold behave the same while the pin drive is released (`en_a_n`=1 or `en_b_n`=1).
- R9: Two blocks behave as one 2*WIDTH-bit register when each end serial output feeds the neighbouring serial input and the two blocks share mode and reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| srst_n | input | 1 | Synchronous reset, active low |
| mode | input | 2 | Operation select: 00 hold, 01 shift up, 10 shift down, 11 load |
| en_a_n | input | 1 | Pin drive enable A, active low |
| en_b_n | input | 1 | Pin drive enable B, active low |
| ser_in_lo | input | 1 | Serial input into bit 0 on shift up |
| ser_in_hi | input | 1 | Serial input into bit WIDTH-1 on shift down |
| pad_i | input | WIDTH | Value seen on the shared pins |
| pad_o | output | WIDTH | Value to drive onto the shared pins |
| pad_oe | output | WIDTH | Drive enable for each shared pin |
| ser_out_lo | output | 1 | Bit 0 of the register |
| ser_out_hi | output | 1 | Bit WIDTH-1 of the register |

## Verification
On every cycle, the assertions check the next-state rule of each mode, the priority of reset, the drive-enable rule and the wiring of the serial outputs. These checks are written in terms of the top-level ports. Only the bench scenarios can show that a chain of two blocks carries bits across the boundary in both directions. The same holds for reset under each of the four select codes, and for operation while the pins are released. The bench compares both the single block and the chain against a behavioural model.

// File: rtl/usr_pkg.sv
package usr_pkg;
  typedef enum logic [2:0] {
    OP_CLR  = 3'd0,
    OP_HOLD = 3'd1,
    OP_UP   = 3'd2,
    OP_DOWN = 3'd3,
    OP_LOAD = 3'd4
  } op_e;

  localparam logic [1:0] MODE_HOLD = 2'b00;
  localparam logic [1:0] MODE_UP   = 2'b01;
  localparam logic [1:0] MODE_DOWN = 2'b10;
  localparam logic [1:0] MODE_LOAD = 2'b11;
endpackage

// File: rtl/usr_mode_dec.sv
module usr_mode_dec
  import usr_pkg::*;
(
  input  logic       srst_n,
  input  logic [1:0] mode,
  output op_e        op,
  output logic       load_sel
);
  assign load_sel = (mode == MODE_LOAD);

  always_comb begin
    if (!srst_n) op = OP_CLR;
    else begin
      unique case (mode)
        MODE_UP:   op = OP_UP;
        MODE_DOWN: op = OP_DOWN;
        MODE_LOAD: op = OP_LOAD;
        default:   op = OP_HOLD;
      endcase
    end
  end
endmodule

// File: rtl/usr_bit_slice.sv
module usr_bit_slice
  import usr_pkg::*;
(
  input  op_e  op,
  input  logic cur,
  input  logic from_lower,
  input  logic from_upper,
  input  logic pad,
  output logic nxt
);
  always_comb begin
    unique case (op)
      OP_CLR:  nxt = 1'b0;
      OP_UP:   nxt = from_lower;
      OP_DOWN: nxt = from_upper;
      OP_LOAD: nxt = pad;
      default: nxt = cur;
    endcase
  end
endmodule

// File: rtl/usr_pad_ctl.sv
module usr_pad_ctl #(
  parameter int WIDTH = 8
) (
  input  logic             en_a_n,
  input  logic             en_b_n,
  input  logic             load_sel,
  output logic [WIDTH-1:0] pad_oe
);
  logic drive;
  assign drive  = ~en_a_n & ~en_b_n & ~load_sel;
  assign pad_oe = {WIDTH{drive}};
endmodule

// File: rtl/usr_shift_reg.sv
module usr_shift_reg
  import usr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             srst_n,
  input  logic [1:0]       mode,
  input  logic             en_a_n,
  input  logic             en_b_n,
  input  logic             ser_in_lo,
  input  logic             ser_in_hi,
  input  logic [WIDTH-1:0] pad_i,
  output logic [WIDTH-1:0] pad_o,
  output logic [WIDTH-1:0] pad_oe,
  output logic             ser_out_lo,
  output logic             ser_out_hi
);
  localparam int MSB = WIDTH - 1;

  op_e              op;
  logic             load_sel;
  logic [WIDTH-1:0] q;
  logic [WIDTH-1:0] q_nxt;

  usr_mode_dec u_dec (
    .srst_n   (srst_n),
    .mode     (mode),
    .op       (op),
    .load_sel (load_sel)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic lower_src;
    logic upper_src;
    if (i == 0) begin : g_lo_end
      assign lower_src = ser_in_lo;
    end else begin : g_lo_mid
      assign lower_src = q[i-1];
    end
    if (i == MSB) begin : g_hi_end
      assign upper_src = ser_in_hi;
    end else begin : g_hi_mid
      assign upper_src = q[i+1];
    end

    usr_bit_slice u_slice (
      .op         (op),
      .cur        (q[i]),
      .from_lower (lower_src),
      .from_upper (upper_src),
      .pad        (pad_i[i]),
      .nxt        (q_nxt[i])
    );
  end

  always_ff @(posedge clk) q <= q_nxt;

  usr_pad_ctl #(.WIDTH(WIDTH)) u_pad (
    .en_a_n   (en_a_n),
    .en_b_n   (en_b_n),
    .load_sel (load_sel),
    .pad_oe   (pad_oe)
  );

  assign pad_o      = q;
  assign ser_out_lo = q[0];
  assign ser_out_hi = q[MSB];

  logic past_valid = 1'b0;
  always_ff @(posedge clk) past_valid <= 1'b1;

  // R1
  reset_clears_chk: assert property (@(posedge clk) disable iff (!past_valid)
    !srst_n |=> pad_o == '0);

  // R2
  load_capture_chk: assert property (@(posedge clk) disable iff (!past_valid)
    (srst_n && mode == MODE_LOAD) |=> pad_o == $past(pad_i));

  // R3
  shift_up_chk: assert property (@(posedge clk) disable iff (!past_valid)
    (srst_n && mode == MODE_UP) |=> pad_o == {$past(pad_o[WIDTH-2:0]), $past(ser_in_lo)});

  // R4
  shift_down_chk: assert property (@(posedge clk) disable iff (!past_valid)
    (srst_n && mode == MODE_DOWN) |=> pad_o == {$past(ser_in_hi), $past(pad_o[MSB:1])});

  // R5
  hold_stable_chk: assert property (@(posedge clk) disable iff (!past_valid)
    (srst_n && mode == MODE_HOLD) |=> $stable(pad_o));

  // R6
  oe_release_chk: assert property (@(posedge clk)
    (en_a_n || en_b_n || mode == MODE_LOAD) |-> pad_oe == '0);

  // R6
  oe_drive_chk: assert property (@(posedge clk)
    (!en_a_n && !en_b_n && mode != MODE_LOAD) |-> pad_oe == '1);

  // R7
  serial_out_chk: assert property (@(posedge clk) disable iff (!past_valid)
    ser_out_lo == pad_o[0] && ser_out_hi == pad_o[MSB]);
endmodule

// File: tb/usr_shift_reg_bench.sv
module usr_shift_reg_bench;
  localparam int W = 8;
  localparam int CYCLES = 3000;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic srst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic en_a_n = 1'b1, en_b_n = 1'b1;
  logic sil = 1'b0, sih = 1'b0;
  logic [W-1:0] pin_a = '0, pin_b = '0;

  logic [W-1:0] po, poe;
  logic sol, soh;

  usr_shift_reg #(.WIDTH(W)) u_usr_shift_reg (
    .clk(clk), .srst_n(srst_n), .mode(mode), .en_a_n(en_a_n), .en_b_n(en_b_n),
    .ser_in_lo(sil), .ser_in_hi(sih), .pad_i(pin_a),
    .pad_o(po), .pad_oe(poe), .ser_out_lo(sol), .ser_out_hi(soh));

  // R9 chain: A is the low half, B the high half
  logic [W-1:0] ca_po, ca_oe, cb_po, cb_oe;
  logic ca_sol, ca_soh, cb_sol, cb_soh;

  usr_shift_reg #(.WIDTH(W)) u_chain_lo (
    .clk(clk), .srst_n(srst_n), .mode(mode), .en_a_n(en_a_n), .en_b_n(en_b_n),
    .ser_in_lo(sil), .ser_in_hi(cb_sol), .pad_i(pin_a),
    .pad_o(ca_po), .pad_oe(ca_oe), .ser_out_lo(ca_sol), .ser_out_hi(ca_soh));

  usr_shift_reg #(.WIDTH(W)) u_chain_hi (
    .clk(clk), .srst_n(srst_n), .mode(mode), .en_a_n(en_a_n), .en_b_n(en_b_n),
    .ser_in_lo(ca_soh), .ser_in_hi(sih), .pad_i(pin_b),
    .pad_o(cb_po), .pad_oe(cb_oe), .ser_out_lo(cb_sol), .ser_out_hi(cb_soh));

  // behavioural reference
  int unsigned ref_q;
  int unsigned ref_chain;
  string tag = "R1";

  always @(posedge clk) begin
    if (!srst_n) begin
      ref_q = 0; ref_chain = 0; tag = "R1";
    end else begin
      case (mode)
        2'b11: begin
          ref_q = int'(pin_a);
          ref_chain = int'(pin_b) * 256 + int'(pin_a);
          tag = "R2";
        end
        2'b01: begin
          ref_q = (ref_q * 2 + int'(sil)) % 256;
          ref_chain = (ref_chain * 2 + int'(sil)) % 65536;
          tag = "R3";
        end
        2'b10: begin
          ref_q = ref_q / 2 + (sih ? 128 : 0);
          ref_chain = ref_chain / 2 + (sih ? 32768 : 0);
          tag = "R4";
        end
        default: tag = "R5";
      endcase
    end
    if (en_a_n || en_b_n) tag = {tag, "/R8"};
  end

  int checks = 0;
  int failures = 0;

  task automatic check(input string req, input int unsigned got, input int unsigned exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%0h exp=%0h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic compare_all();
    int unsigned exp_oe;
    exp_oe = (!en_a_n && !en_b_n && mode != 2'b11) ? 255 : 0;
    check(tag, int'(po), ref_q);
    check("R7", {30'd0, soh, sol}, {30'd0, ref_q[7], ref_q[0]});
    check("R6", int'(poe), exp_oe);
    check({"R9 ", tag}, int'(cb_po) * 256 + int'(ca_po), ref_chain);
    check("R9 R7", {30'd0, cb_soh, ca_sol}, {30'd0, ref_chain[15], ref_chain[0]});
  endtask

  bit done = 1'b0;

  initial begin
    // reset state
    @(posedge clk);
    @(negedge clk);
    compare_all();

    // R1: reset combined with every select code, after loading ones
    for (int m = 0; m < 4; m++) begin
      srst_n = 1'b1; mode = 2'b11; pin_a = 8'hff; pin_b = 8'h5a;
      @(negedge clk); compare_all();
      srst_n = 1'b0; mode = 2'(m); en_a_n = m[0]; en_b_n = 1'b0;
      @(negedge clk); compare_all();
    end

    // R3/R4/R9: walk a single one across the chain boundary both ways
    srst_n = 1'b1; en_a_n = 1'b0; en_b_n = 1'b0;
    mode = 2'b01; sil = 1'b1;
    @(negedge clk); compare_all();
    sil = 1'b0;
    for (int k = 0; k < 2 * W; k++) begin @(negedge clk); compare_all(); end
    mode = 2'b10; sih = 1'b1;
    @(negedge clk); compare_all();
    sih = 1'b0;
    for (int k = 0; k < 2 * W; k++) begin @(negedge clk); compare_all(); end

    // mixed traffic
    for (int k = 0; k < CYCLES; k++) begin
      srst_n = ($urandom_range(0, 19) != 0);
      mode   = 2'($urandom_range(0, 3));
      en_a_n = ($urandom_range(0, 3) == 0);
      en_b_n = ($urandom_range(0, 3) == 0);
      sil    = 1'($urandom_range(0, 1));
      sih    = 1'($urandom_range(0, 1));
      pin_a  = 8'($urandom_range(0, 255));
      pin_b  = 8'($urandom_range(0, 255));
      #1;
      check("R6", int'(poe), (!en_a_n && !en_b_n && mode != 2'b11) ? 255 : 0);
      @(negedge clk);
      compare_all();
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule